// File: doc/BRIEF.md
# Configurable Serial Receive Framer

This block takes a synchronous serial bit stream, framed by a single-bit-period frame-sync pulse, and rebuilds it into parallel words. A static set of configuration inputs describes the frame. A frame has either one phase or two phases in sequence. Each phase has its own word count (1 to 128) and word width (8 to 32 bits). The configuration also sets a gap of zero, one or two bit periods between the sync pulse and the first data bit, the bit order for byte-wide words, and whether a sync pulse that arrives during a frame restarts the frame or is ignored.

Every completed word leaves the block right-justified and zero-extended to 32 bits. It comes with a one-cycle valid strobe, a tag that names the phase it belongs to, and its index within that phase. Two sticky flags report problems. The first flags a configuration that uses a reserved code. The second flags a frame that was cut short by a restart. The block is clocked by the receive bit clock and has a synchronous active-high reset.

Top module: `serial_rx_framer`

## Requirements
- R1: After an accepted sync pulse with `cfg_dual`=0, the block delivers exactly `cfg_cnt1`+1 words. Each of these words has `word_phase`=1 (encoding 2'b01), and `word_idx` counts up from 0.
- R2: With `cfg_dual`=1, the `cfg_cnt2`+1 words of phase 2 follow the phase-1 words in the same frame with no extra sync. They carry `word_phase`=2 (encoding 2'b10), and `word_idx` starts again at 0.
- R3: The width codes map as follows: 0 is 8 bits, 1 is 12, 2 is 16, 3 is 20, 4 is 24 and 5 is 32. Each word appears right-justified on `word_data`, with every bit above its width at zero.
- R4: `cfg_delay` values 0, 1 and 2 place the first data bit on the same rising edge as the sync pulse, on the next edge, or two edges later.
- R5: `cfg_order`=1 with width code 0 shifts the byte in LSB first. For wider words, code 1 behaves like code 0 (MSB first). Codes 2 and 3 deliver the raw bits MSB first.
- R6: With `cfg_ignore`=1, sync pulses that arrive while a frame is in progress change neither the delivered words nor `early_sync`.
- R7: With `cfg_ignore`=0, a sync pulse during a frame starts a new frame at once. The partly assembled word is dropped, words already delivered stand, and the sticky `early_sync` is set.
- R8: A width code of 6 or 7 in a phase the frame uses, or a `cfg_delay` of 3, sets the sticky `cfg_err` when a sync pulse is accepted. While `cfg_err` is set, no further words are produced.
- R9: The configuration is captured when a sync pulse is accepted. Changes to the configuration inputs during the frame have no effect on that frame.
- R10: `word_vld` rises in the cycle that follows the edge sampling a word's last bit, and it lasts exactly one cycle.
- R11: During and right after reset, `word_vld`, `word_data`, `cfg_err` and `early_sync` are all 0.
- R12: A sync pulse on the edge that directly follows the last bit of a frame is accepted as the start of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock; inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sdata | input | 1 | Serial data |
| fsync | input | 1 | Frame-sync pulse, active high, one bit period long |
| cfg_dual | input | 1 | 0 = one phase per frame, 1 = two phases |
| cfg_cnt1 | input | 7 | Phase-1 word count minus one |
| cfg_wcode1 | input | 3 | Phase-1 width code |
| cfg_cnt2 | input | 7 | Phase-2 word count minus one |
| cfg_wcode2 | input | 3 | Phase-2 width code |
| cfg_delay | input | 2 | Data delay in bit periods after sync (3 is reserved) |
| cfg_order | input | 2 | Bit-order/compand selection |
| cfg_ignore | input | 1 | 1 = ignore sync pulses during a frame, 0 = restart |
| word_data | output | 32 | Received word, right-justified |
| word_vld | output | 1 | One-cycle strobe for word_data |
| word_phase | output | 2 | Phase tag of the word (1 or 2) |
| word_idx | output | 7 | Index of the word within its phase |
| cfg_err | output | 1 | Sticky reserved-configuration flag |
| early_sync | output | 1 | Sticky restarted-frame flag |

## Verification
The assertions assume that `fsync` is a clean pulse that lasts one bit period. They also assume that every width is at least 8 bits, so two valid strobes can never fall on neighbouring cycles, and that the only way the flags rise is through a sync pulse sampled on the previous edge. The bench changes every input on the falling edge only. It builds each frame from whole bit periods, so the sync pulse and the data line up to the edge. Configuration changes inside a frame appear only in the test that covers R9.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SKIP = 2'd1,
    ST_DATA = 2'd2
  } rxf_state_e;

  function automatic logic [7:0] width_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 8'd8;
      3'd1:    return 8'd12;
      3'd2:    return 8'd16;
      3'd3:    return 8'd20;
      3'd4:    return 8'd24;
      3'd5:    return 8'd32;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic width_ok(input logic [2:0] code);
    return code <= 3'd5;
  endfunction

endpackage

// File: rtl/rxf_cfg_check.sv
module rxf_cfg_check #(
  parameter int BITS_W = 6
) (
  input  logic              dual,
  input  logic [2:0]        wcode1,
  input  logic [2:0]        wcode2,
  input  logic [1:0]        dly,
  input  logic [1:0]        order,
  output logic              bad,
  output logic [BITS_W-1:0] bits1,
  output logic [BITS_W-1:0] bits2,
  output logic              lsb1,
  output logic              lsb2
);
  import rxf_pkg::*;

  logic [7:0] b1_full, b2_full;

  always_comb begin
    b1_full = width_bits(wcode1);
    b2_full = width_bits(wcode2);
    bits1   = b1_full[BITS_W-1:0];
    bits2   = b2_full[BITS_W-1:0];
    bad     = !width_ok(wcode1) || (dual && !width_ok(wcode2)) || (dly == 2'd3);
    lsb1    = (order == 2'd1) && (wcode1 == 3'd0);
    lsb2    = (order == 2'd1) && (wcode2 == 3'd0);
  end

endmodule

// File: rtl/rxf_seq.sv
module rxf_seq #(
  parameter int CNT_W  = 7,
  parameter int BITS_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  input  logic              in_dual,
  input  logic [CNT_W-1:0]  in_cnt1,
  input  logic [CNT_W-1:0]  in_cnt2,
  input  logic [BITS_W-1:0] in_bits1,
  input  logic [BITS_W-1:0] in_bits2,
  input  logic              in_lsb1,
  input  logic              in_lsb2,
  input  logic [1:0]        in_dly,
  input  logic              in_ign,
  input  logic              in_bad,
  output logic              take,
  output logic              first,
  output logic              lsb_eff,
  output logic              last,
  output logic              ph_eff,
  output logic [CNT_W-1:0]  idx_eff,
  output logic              cfg_err,
  output logic              early_sync
);
  import rxf_pkg::*;

  rxf_state_e        st_q;
  logic [1:0]        skip_q;
  logic              ph_q;
  logic [CNT_W-1:0]  widx_q;
  logic [BITS_W-1:0] bcnt_q;
  logic              dual_q, lsb1_q, lsb2_q, ign_q;
  logic [CNT_W-1:0]  cnt1_q, cnt2_q;
  logic [BITS_W-1:0] bits1_q, bits2_q;
  logic              err_q, early_q;

  logic              accept, restart, start;
  logic [BITS_W-1:0] bcnt_eff, bits_eff;
  logic [CNT_W-1:0]  cnt_cur;

  assign accept  = fsync && !err_q && ((st_q == ST_IDLE) || !ign_q);
  assign restart = accept && (st_q != ST_IDLE);
  assign start   = accept && !in_bad;
  assign cnt_cur = ph_q ? cnt2_q : cnt1_q;

  always_comb begin
    take     = 1'b0;
    bcnt_eff = '0;
    if (start) begin
      take     = (in_dly == 2'd0);
      ph_eff   = 1'b0;
      idx_eff  = '0;
      bits_eff = in_bits1;
      lsb_eff  = in_lsb1;
    end else begin
      ph_eff   = ph_q;
      idx_eff  = widx_q;
      bits_eff = ph_q ? bits2_q : bits1_q;
      lsb_eff  = ph_q ? lsb2_q : lsb1_q;
      case (st_q)
        ST_SKIP: take = (skip_q == 2'd1);
        ST_DATA: begin
          take     = 1'b1;
          bcnt_eff = bcnt_q;
        end
        default: take = 1'b0;
      endcase
    end
    first = take && (bcnt_eff == '0);
    last  = take && (bcnt_eff == bits_eff - BITS_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      skip_q  <= '0;
      ph_q    <= 1'b0;
      widx_q  <= '0;
      bcnt_q  <= '0;
      dual_q  <= 1'b0;
      lsb1_q  <= 1'b0;
      lsb2_q  <= 1'b0;
      ign_q   <= 1'b0;
      cnt1_q  <= '0;
      cnt2_q  <= '0;
      bits1_q <= '0;
      bits2_q <= '0;
      err_q   <= 1'b0;
      early_q <= 1'b0;
    end else if (accept && in_bad) begin
      err_q <= 1'b1;
      st_q  <= ST_IDLE;
      if (restart) early_q <= 1'b1;
    end else if (start) begin
      dual_q  <= in_dual;
      cnt1_q  <= in_cnt1;
      cnt2_q  <= in_cnt2;
      bits1_q <= in_bits1;
      bits2_q <= in_bits2;
      lsb1_q  <= in_lsb1;
      lsb2_q  <= in_lsb2;
      ign_q   <= in_ign;
      ph_q    <= 1'b0;
      widx_q  <= '0;
      if (restart) early_q <= 1'b1;
      if (in_dly == 2'd0) begin
        st_q   <= ST_DATA;
        bcnt_q <= BITS_W'(1);
      end else begin
        st_q   <= ST_SKIP;
        skip_q <= in_dly;
        bcnt_q <= '0;
      end
    end else begin
      case (st_q)
        ST_SKIP: begin
          if (skip_q == 2'd1) begin
            st_q   <= ST_DATA;
            bcnt_q <= BITS_W'(1);
          end else begin
            skip_q <= skip_q - 2'd1;
          end
        end
        ST_DATA: begin
          if (last) begin
            bcnt_q <= '0;
            if (widx_q == cnt_cur) begin
              widx_q <= '0;
              if (!ph_q && dual_q) ph_q <= 1'b1;
              else                 st_q <= ST_IDLE;
            end else begin
              widx_q <= widx_q + CNT_W'(1);
            end
          end else begin
            bcnt_q <= bcnt_q + BITS_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg_err    = err_q;
  assign early_sync = early_q;

endmodule

// File: rtl/rxf_shift.sv
module rxf_shift #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              first,
  input  logic              lsb,
  input  logic              sdata,
  output logic [WORD_W-1:0] nxt
);
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] base;

  always_comb begin
    base = first ? '0 : sh_q;
    if (lsb) begin
      nxt               = '0;
      nxt[BYTE_W-1]     = sdata;
      nxt[BYTE_W-2:0]   = base[BYTE_W-1:1];
    end else begin
      nxt = {base[WORD_W-2:0], sdata};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       sh_q <= '0;
    else if (take) sh_q <= nxt;
  end

endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 7,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdata,
  input  logic              fsync,
  input  logic              cfg_dual,
  input  logic [CNT_W-1:0]  cfg_cnt1,
  input  logic [2:0]        cfg_wcode1,
  input  logic [CNT_W-1:0]  cfg_cnt2,
  input  logic [2:0]        cfg_wcode2,
  input  logic [1:0]        cfg_delay,
  input  logic [1:0]        cfg_order,
  input  logic              cfg_ignore,
  output logic [WORD_W-1:0] word_data,
  output logic              word_vld,
  output logic [1:0]        word_phase,
  output logic [CNT_W-1:0]  word_idx,
  output logic              cfg_err,
  output logic              early_sync
);
  localparam int BITS_W = $clog2(WORD_W) + 1;

  logic              bad;
  logic [BITS_W-1:0] bits1, bits2;
  logic              lsb1, lsb2;
  logic              take, first, lsb_eff, last, ph_eff;
  logic [CNT_W-1:0]  idx_eff;
  logic [WORD_W-1:0] nxt;

  rxf_cfg_check #(.BITS_W(BITS_W)) u_cfg (
    .dual   (cfg_dual),
    .wcode1 (cfg_wcode1),
    .wcode2 (cfg_wcode2),
    .dly    (cfg_delay),
    .order  (cfg_order),
    .bad    (bad),
    .bits1  (bits1),
    .bits2  (bits2),
    .lsb1   (lsb1),
    .lsb2   (lsb2)
  );

  rxf_seq #(.CNT_W(CNT_W), .BITS_W(BITS_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .fsync      (fsync),
    .in_dual    (cfg_dual),
    .in_cnt1    (cfg_cnt1),
    .in_cnt2    (cfg_cnt2),
    .in_bits1   (bits1),
    .in_bits2   (bits2),
    .in_lsb1    (lsb1),
    .in_lsb2    (lsb2),
    .in_dly     (cfg_delay),
    .in_ign     (cfg_ignore),
    .in_bad     (bad),
    .take       (take),
    .first      (first),
    .lsb_eff    (lsb_eff),
    .last       (last),
    .ph_eff     (ph_eff),
    .idx_eff    (idx_eff),
    .cfg_err    (cfg_err),
    .early_sync (early_sync)
  );

  rxf_shift #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .take  (take),
    .first (first),
    .lsb   (lsb_eff),
    .sdata (sdata),
    .nxt   (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_data  <= '0;
      word_vld   <= 1'b0;
      word_phase <= '0;
      word_idx   <= '0;
    end else begin
      word_vld <= last;
      if (last) begin
        word_data  <= nxt;
        word_phase <= {ph_eff, !ph_eff};
        word_idx   <= idx_eff;
      end
    end
  end

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
  input logic       clk,
  input logic       rst,
  input logic       fsync,
  input logic       word_vld,
  input logic [1:0] word_phase,
  input logic       cfg_err,
  input logic       early_sync
);

  AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld); // R10

  AST_PHASE_TAG_LEGAL: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> (word_phase == 2'd1 || word_phase == 2'd2)); // R2

  AST_CFG_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err); // R8

  AST_CFG_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && $past(cfg_err)) |-> !word_vld); // R8

  AST_EARLY_STICKY: assert property (@(posedge clk) disable iff (rst)
    early_sync |=> early_sync); // R7

  AST_EARLY_NEEDS_SYNC: assert property (@(posedge clk) disable iff (rst)
    $rose(early_sync) |-> $past(fsync)); // R7

  AST_CFG_ERR_NEEDS_SYNC: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_err) |-> $past(fsync)); // R8

endmodule

bind serial_rx_framer rxf_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .fsync      (fsync),
  .word_vld   (word_vld),
  .word_phase (word_phase),
  .cfg_err    (cfg_err),
  .early_sync (early_sync)
);

// File: tb/tb_serial_rx_framer.sv
module tb_serial_rx_framer;

  logic        clk = 1'b0;
  logic        rst;
  logic        sdata, fsync;
  logic        cfg_dual, cfg_ignore;
  logic [6:0]  cfg_cnt1, cfg_cnt2;
  logic [2:0]  cfg_wcode1, cfg_wcode2;
  logic [1:0]  cfg_delay, cfg_order;
  logic [31:0] word_data;
  logic        word_vld;
  logic [1:0]  word_phase;
  logic [6:0]  word_idx;
  logic        cfg_err, early_sync;

  always #5 clk = ~clk;

  serial_rx_framer dut (
    .clk(clk), .rst(rst), .sdata(sdata), .fsync(fsync),
    .cfg_dual(cfg_dual), .cfg_cnt1(cfg_cnt1), .cfg_wcode1(cfg_wcode1),
    .cfg_cnt2(cfg_cnt2), .cfg_wcode2(cfg_wcode2), .cfg_delay(cfg_delay),
    .cfg_order(cfg_order), .cfg_ignore(cfg_ignore),
    .word_data(word_data), .word_vld(word_vld), .word_phase(word_phase),
    .word_idx(word_idx), .cfg_err(cfg_err), .early_sync(early_sync)
  );

  typedef struct packed {
    logic [31:0] d;
    logic [1:0]  ph;
    logic [6:0]  idx;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad = 0;
  int   pos;
  int   extra_at;
  bit   scramble;
  bit   expect_on = 1'b1;

  function automatic int wbits(input logic [2:0] c);
    case (c)
      3'd0: return 8;
      3'd1: return 12;
      3'd2: return 16;
      3'd3: return 20;
      3'd4: return 24;
      default: return 32;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic fs, input logic b);
    @(negedge clk);
    fsync = fs;
    sdata = b;
  endtask

  task automatic idle(input int n);
    repeat (n) drive(1'b0, 1'b0);
  endtask

  task automatic emit(input logic b);
    drive((pos == 0) || (extra_at > 0 && pos == extra_at), b);
    if (scramble && pos == 3) begin
      cfg_dual   = ~cfg_dual;
      cfg_cnt1   = 7'($urandom);
      cfg_cnt2   = 7'($urandom);
      cfg_wcode1 = 3'($urandom);
      cfg_wcode2 = 3'($urandom);
      cfg_delay  = 2'($urandom);
      cfg_order  = 2'($urandom);
    end
    pos++;
  endtask

  // drives one frame; abort_at > 0 stops after that many data bits
  task automatic send_frame(input bit dual, input int c1, input logic [2:0] w1,
                            input int c2, input logic [2:0] w2, input int dly,
                            input logic [1:0] ord, input bit ign,
                            input int abort_at, input int xat, input bit scr);
    int nbits;
    cfg_dual = dual; cfg_cnt1 = 7'(c1); cfg_cnt2 = 7'(c2);
    cfg_wcode1 = w1; cfg_wcode2 = w2; cfg_delay = 2'(dly);
    cfg_order = ord; cfg_ignore = ign;
    pos = 0; extra_at = xat; scramble = scr; nbits = 0;
    for (int k = 0; k < dly; k++) emit(1'b0);
    for (int ph = 0; ph < (dual ? 2 : 1); ph++) begin
      logic [2:0]  wc;
      int          w, cnt;
      bit          lsbf;
      wc   = (ph == 0) ? w1 : w2;
      w    = wbits(wc);
      cnt  = (ph == 0) ? c1 : c2;
      lsbf = (ord == 2'd1) && (wc == 3'd0);
      for (int wi = 0; wi <= cnt; wi++) begin
        logic [31:0] d;
        exp_t        e;
        d = $urandom;
        if (w < 32) d = d & ((32'd1 << w) - 32'd1);
        for (int b = 0; b < w; b++) begin
          emit(lsbf ? d[b] : d[w-1-b]);
          nbits++;
          if (abort_at > 0 && nbits == abort_at) begin
            scramble = 1'b0;
            return;
          end
        end
        e.d = d; e.ph = (ph == 0) ? 2'd1 : 2'd2; e.idx = 7'(wi);
        if (expect_on) q.push_back(e);
      end
    end
    scramble = 1'b0;
  endtask

  // monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (!rst && word_vld) begin
      if (q.size() == 0) begin
        total++; bad++;
        $display("FAIL R1 R8 unexpected word: actual=%0h expected=none", word_data);
      end else begin
        exp_t e;
        e = q.pop_front();
        check("R1 R3 R4 R5", "word_data", word_data, e.d);
        check("R1 R2", "word_phase", 32'(word_phase), 32'(e.ph));
        check("R1 R2", "word_idx", 32'(word_idx), 32'(e.idx));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; sdata = 0; fsync = 0; cfg_dual = 0; cfg_ignore = 1;
    cfg_cnt1 = 0; cfg_cnt2 = 0; cfg_wcode1 = 0; cfg_wcode2 = 0;
    cfg_delay = 0; cfg_order = 0; extra_at = 0; scramble = 0; pos = 0;
    repeat (4) @(negedge clk);
    check("R11", "word_vld in reset", 32'(word_vld), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R11", "word_vld", 32'(word_vld), 0);
    check("R11", "word_data", word_data, 0);
    check("R11", "cfg_err", 32'(cfg_err), 0);
    check("R11", "early_sync", 32'(early_sync), 0);

    // R1 single phase, three 16-bit words, delay 1
    send_frame(0, 2, 3'd2, 0, 3'd0, 1, 2'd0, 1, 0, 0, 0);
    idle(3);
    // R3 every width code, delay 0
    for (int c = 0; c < 6; c++) begin
      send_frame(0, 1, 3'(c), 0, 3'd0, 0, 2'd0, 1, 0, 0, 0);
      idle(2);
    end
    // R2 dual phase, 12-bit then 32-bit, R4 delay 2
    send_frame(1, 2, 3'd1, 3, 3'd5, 2, 2'd0, 1, 0, 0, 0);
    idle(3);
    // R5 bit order variants
    send_frame(0, 3, 3'd0, 0, 3'd0, 1, 2'd1, 1, 0, 0, 0);
    idle(2);
    send_frame(0, 1, 3'd2, 0, 3'd0, 0, 2'd1, 1, 0, 0, 0);
    idle(2);
    send_frame(0, 1, 3'd0, 0, 3'd0, 0, 2'd2, 1, 0, 0, 0);
    idle(2);
    send_frame(1, 1, 3'd0, 1, 3'd4, 2, 2'd1, 1, 0, 0, 0);
    idle(3);
    // R12 back-to-back frames
    send_frame(0, 1, 3'd0, 0, 3'd0, 0, 2'd0, 1, 0, 0, 0);
    send_frame(0, 0, 3'd1, 0, 3'd0, 0, 2'd0, 1, 0, 0, 0);
    idle(3);
    check("R12", "scoreboard drained", 32'(q.size()), 0);
    // R9 configuration changed mid-frame
    send_frame(1, 2, 3'd2, 1, 3'd0, 1, 2'd0, 1, 0, 0, 1);
    idle(3);
    check("R9", "scoreboard drained", 32'(q.size()), 0);
    // R6 extra sync ignored
    send_frame(0, 3, 3'd0, 0, 3'd0, 1, 2'd0, 1, 0, 10, 0);
    idle(3);
    check("R6", "early_sync", 32'(early_sync), 0);
    check("R6", "scoreboard drained", 32'(q.size()), 0);
    // R10 strobe timing: one 8-bit word, delay 0
    send_frame(0, 0, 3'd0, 0, 3'd0, 0, 2'd0, 1, 0, 0, 0);
    check("R10", "word_vld before last edge", 32'(word_vld), 0);
    @(negedge clk); fsync = 0; sdata = 0;
    check("R10", "word_vld after last edge", 32'(word_vld), 1);
    @(negedge clk);
    check("R10", "word_vld one cycle later", 32'(word_vld), 0);
    idle(2);
    // R7 restart mid-word
    send_frame(0, 5, 3'd0, 0, 3'd0, 1, 2'd0, 0, 20, 0, 0);
    send_frame(0, 1, 3'd0, 0, 3'd0, 0, 2'd0, 0, 0, 0, 0);
    idle(3);
    check("R7", "early_sync", 32'(early_sync), 1);
    check("R7", "scoreboard drained", 32'(q.size()), 0);
    // R8 reserved phase-2 width
    expect_on = 1'b0;
    send_frame(1, 0, 3'd0, 0, 3'd7, 0, 2'd0, 1, 0, 0, 0);
    idle(2);
    check("R8", "cfg_err reserved width", 32'(cfg_err), 1);
    send_frame(0, 1, 3'd0, 0, 3'd0, 0, 2'd0, 1, 0, 0, 0);
    idle(3);
    check("R8", "cfg_err still set", 32'(cfg_err), 1);
    // R11 reset clears, then R8 reserved delay
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R11", "cfg_err after reset", 32'(cfg_err), 0);
    check("R11", "early_sync after reset", 32'(early_sync), 0);
    send_frame(0, 0, 3'd0, 0, 3'd0, 3, 2'd0, 1, 0, 0, 0);
    idle(3);
    check("R8", "cfg_err reserved delay", 32'(cfg_err), 1);
    check("R8", "no words queued", 32'(q.size()), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule